// File: doc/BRIEF.md
# Timer Capture/Compare Channel

This block is a single channel of a general-purpose timer. It watches a shared counter that lives outside the block, together with strobes that say when the counter advanced, when it wrapped to zero, and when control logic forced it back to zero. Two small configuration fields pick the channel's role. It can leave its pin under port control with a preset level. It can timestamp edges on an input pin. It can drive an output pin that is set, cleared or toggled when the counter reaches a programmed value.

The channel owns a counter-width value register, an event flag with a read-then-write clear sequence, a request enable and a routing bit that sends requests either to the processor interrupt line or to the DMA request line. For unbuffered pulse-width modulation it can also toggle its output on every counter wrap. A max-duty control holds the output at its active level for whole periods. That control only takes effect at a period boundary.

Top module: `tcc_channel`

## Requirements
- R1: With `edge_lvl` = 00 the channel does not drive its pin (`pin_oe` = 0), and one clock later `pin_out` is high when `mode[0]` = 0 and low when `mode[0]` = 1. After reset `pin_out` is 1, `pin_oe`, `flag`, `irq` and `dma_req` are 0, and `ch_val` is 0.
- R2: With `mode` = 00, `edge_lvl` 01, 10 or 11 captures on rising, falling or either edge of `pin_in`. The input passes a two-flop synchroniser, and the capture lands within four clocks of the pin change. On a capture, `ch_val` takes the value `cnt` has in the capture cycle and `flag` is set. An edge of the wrong polarity changes nothing.
- R3: With `mode` other than 00 and `edge_lvl` 01, 10 or 11, a cycle with `cnt_upd` = 1 and `cnt` equal to `ch_val` toggles, clears or sets `pin_out` and sets `flag`. Cycles with `cnt_upd` = 0 take no compare action. `val_wr` loads `val_in` into `ch_val`.
- R4: With `tov_en` = 1 in a compare mode, `pin_out` inverts on each cycle with `cnt_ovf` = 1. In capture mode (`mode` = 00) `tov_en` leaves `pin_out` unchanged.
- R5: When a wrap (`cnt_ovf`) and a compare match fall in the same cycle with `tov_en` = 1, the output toggles and the compare action is dropped. The flag is still set.
- R6: A `ch_val` above the counter's wrap value never produces a match: neither `flag` nor `pin_out` changes.
- R7: `max_duty` is sampled only at a wrap or a counter reset. While the sampled value is 1, `pin_out` holds the forced level, which is 0 when `edge_lvl` = 11 and 1 otherwise. The wrap that ends a forced period also drives the forced level.
- R8: `flag` clears only when `flag_wr0` follows an earlier `stat_rd` made while `flag` was 1. A `flag_wr0` with no such read leaves `flag` at 1.
- R9: `flag` AND `req_en` drives `irq` when `dma_sel` = 0 and `dma_req` when `dma_sel` = 1. This routing also applies when `edge_lvl` = 00.
- R10: In a mode where `edge_lvl` is not 00, `cnt_rst` drives `pin_out` to 0 when `edge_lvl` = 10 and to 1 when `edge_lvl` = 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt | input | CW | Shared counter value |
| cnt_upd | input | 1 | Counter advanced this cycle |
| cnt_ovf | input | 1 | Counter wrapped to zero this cycle |
| cnt_rst | input | 1 | Counter forced to zero by control |
| mode | input | 2 | Mode field (00 capture/port, else compare) |
| edge_lvl | input | 2 | Edge or output action select |
| tov_en | input | 1 | Toggle output on counter wrap |
| max_duty | input | 1 | Force full-period active level |
| req_en | input | 1 | Request enable |
| dma_sel | input | 1 | Route request to DMA line |
| val_wr | input | 1 | Write strobe for the channel value |
| val_in | input | CW | Channel value write data |
| stat_rd | input | 1 | Status read strobe (arms flag clear) |
| flag_wr0 | input | 1 | Write of zero to the flag |
| pin_in | input | 1 | Capture input pin |
| pin_out | output | 1 | Channel output level |
| pin_oe | output | 1 | Channel drives the pin |
| ch_val | output | CW | Channel value register |
| flag | output | 1 | Channel event flag |
| irq | output | 1 | Processor interrupt request |
| dma_req | output | 1 | DMA service request |

## Verification
The bench drives a counter that wraps after 9, so every compare and max-duty case is reached within a few periods. It sweeps pulse-width output cycle by cycle against the expected duty. A wrap that coincides with a match on zero must toggle the pin. A design that applied the clear instead would keep the pin low for good. Setting and clearing max-duty in the middle of a period must not change the output until the next wrap; a design that applied it at once would change the pin too early. The bench also writes zero to the flag without a prior read, which a design with a one-step clear would wrongly honour. It drives edges of the wrong polarity against each capture select, and a design that decoded the edge select loosely would overwrite the captured value.

// File: rtl/tcc_pkg.sv
// Shared encodings for the timer capture/compare channel.
// Assumes the mode and edge/level fields are two bits wide each.
package tcc_pkg;
    localparam logic [1:0] MODE_CAPTURE = 2'b00;

    localparam logic [1:0] EL_PORT  = 2'b00;
    localparam logic [1:0] EL_RISE  = 2'b01;  // capture: rising; compare: toggle
    localparam logic [1:0] EL_FALL  = 2'b10;  // capture: falling; compare: clear
    localparam logic [1:0] EL_BOTH  = 2'b11;  // capture: any edge; compare: set
endpackage

// File: rtl/tcc_edge_detect.sv
// Synchronises an asynchronous pin and reports single-cycle rising and
// falling pulses. Assumes STAGES >= 1; the pin is treated as low in reset.
module tcc_edge_detect #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    generate
        if (STAGES == 1) begin : g_single
            // Single stage capture of the pin.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= pin;
            end
        end else begin : g_chain
            // Shift the pin through the synchroniser chain.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[STAGES-2:0], pin};
            end
        end
    endgenerate

    // Remember the last synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= sync_q[STAGES-1];
    end

    assign rise = sync_q[STAGES-1] & ~last_q;
    assign fall = ~sync_q[STAGES-1] & last_q;
endmodule

// File: rtl/tcc_flag.sv
// Event flag with a two-step clear: a status read while set arms the
// clear, and a following write of zero clears it. A new event in the
// same cycle as the clearing write keeps the flag set.
module tcc_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic stat_rd,
    input  logic flag_wr0,
    output logic flag
);
    logic armed_q;

    // Track the read that arms the clear; any zero write disarms it.
    always_ff @(posedge clk) begin
        if (!rst_n)        armed_q <= 1'b0;
        else if (flag_wr0) armed_q <= 1'b0;
        else if (stat_rd && flag) armed_q <= 1'b1;
    end

    // Set on events, clear only on an armed zero write.
    always_ff @(posedge clk) begin
        if (!rst_n)                    flag <= 1'b0;
        else if (set_evt)              flag <= 1'b1;
        else if (flag_wr0 && armed_q)  flag <= 1'b0;
    end
endmodule

// File: rtl/tcc_out.sv
// Output level generator: port preset, counter-reset preset, compare
// actions, toggle on wrap (winning over a coincident match) and a
// max-duty override that is sampled only at period boundaries.
module tcc_out
    import tcc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    input  logic [1:0] edge_lvl,
    input  logic       tov_en,
    input  logic       max_duty,
    input  logic       match,
    input  logic       ovf,
    input  logic       cnt_rst,
    output logic       out
);
    logic out_q;
    logic max_eff_q;
    logic cmp_mode;
    logic force_lvl;
    logic match_lvl;

    assign cmp_mode  = (mode != MODE_CAPTURE);
    assign force_lvl = (edge_lvl != EL_BOTH);

    // Level the output takes on a compare match.
    always_comb begin
        case (edge_lvl)
            EL_RISE: match_lvl = ~out_q;
            EL_FALL: match_lvl = 1'b0;
            EL_BOTH: match_lvl = 1'b1;
            default: match_lvl = out_q;
        endcase
    end

    // Sample the max-duty request only at a period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)              max_eff_q <= 1'b0;
        else if (ovf || cnt_rst) max_eff_q <= max_duty;
    end

    // Output register with the priority of presets and actions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= 1'b1;
        end else if (edge_lvl == EL_PORT) begin
            out_q <= ~mode[0];
        end else if (cnt_rst) begin
            if (edge_lvl == EL_FALL)      out_q <= 1'b0;
            else if (edge_lvl == EL_BOTH) out_q <= 1'b1;
        end else if (cmp_mode) begin
            if (ovf && (max_duty || max_eff_q)) out_q <= force_lvl;
            else if (ovf && tov_en)             out_q <= ~out_q;
            else if (max_eff_q)                 out_q <= force_lvl;
            else if (match)                     out_q <= match_lvl;
        end
    end

    assign out = out_q;
endmodule

// File: rtl/tcc_channel.sv
// One capture/compare channel on a shared timer counter. The counter,
// its prescaler and channel pairing live outside. cnt_upd marks cycles
// where cnt holds a freshly advanced value; cnt_ovf marks the wrap.
module tcc_channel
    import tcc_pkg::*;
#(
    parameter int CW          = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt,
    input  logic          cnt_upd,
    input  logic          cnt_ovf,
    input  logic          cnt_rst,
    input  logic [1:0]    mode,
    input  logic [1:0]    edge_lvl,
    input  logic          tov_en,
    input  logic          max_duty,
    input  logic          req_en,
    input  logic          dma_sel,
    input  logic          val_wr,
    input  logic [CW-1:0] val_in,
    input  logic          stat_rd,
    input  logic          flag_wr0,
    input  logic          pin_in,
    output logic          pin_out,
    output logic          pin_oe,
    output logic [CW-1:0] ch_val,
    output logic          flag,
    output logic          irq,
    output logic          dma_req
);
    logic          rise;
    logic          fall;
    logic          cap_mode;
    logic          cmp_mode;
    logic          cap_evt;
    logic          match;
    logic          req;
    logic [CW-1:0] val_q;

    assign cap_mode = (mode == MODE_CAPTURE) && (edge_lvl != EL_PORT);
    assign cmp_mode = (mode != MODE_CAPTURE);

    tcc_edge_detect #(.STAGES(SYNC_STAGES)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (pin_in),
        .rise (rise),
        .fall (fall)
    );

    // Decide whether the synchronised edge matches the selected polarity.
    always_comb begin
        case (edge_lvl)
            EL_RISE: cap_evt = cap_mode & rise;
            EL_FALL: cap_evt = cap_mode & fall;
            EL_BOTH: cap_evt = cap_mode & (rise | fall);
            default: cap_evt = 1'b0;
        endcase
    end

    assign match = cmp_mode && cnt_upd && (cnt == val_q);

    // Channel value: capture has priority over a software write.
    always_ff @(posedge clk) begin
        if (!rst_n)       val_q <= '0;
        else if (cap_evt) val_q <= cnt;
        else if (val_wr)  val_q <= val_in;
    end

    tcc_flag u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (cap_evt | match),
        .stat_rd (stat_rd),
        .flag_wr0(flag_wr0),
        .flag    (flag)
    );

    tcc_out u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode),
        .edge_lvl(edge_lvl),
        .tov_en  (tov_en),
        .max_duty(max_duty),
        .match   (match),
        .ovf     (cnt_ovf),
        .cnt_rst (cnt_rst),
        .out     (pin_out)
    );

    assign pin_oe  = cmp_mode && (edge_lvl != EL_PORT);
    assign ch_val  = val_q;
    assign req     = flag & req_en;
    assign irq     = req & ~dma_sel;
    assign dma_req = req & dma_sel;
endmodule

// File: rtl/tcc_channel_chk.sv
// Property checker for tcc_channel, attached by bind below.
module tcc_channel_chk #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    mode,
    input logic [1:0]    edge_lvl,
    input logic          cnt_rst,
    input logic          val_wr,
    input logic          flag_wr0,
    input logic          flag,
    input logic          pin_out,
    input logic          req_en,
    input logic          dma_sel,
    input logic          irq,
    input logic          dma_req,
    input logic [CW-1:0] ch_val
);
    p_port_preset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_lvl == 2'b00) |=> (pin_out == !$past(mode[0])));

    p_capture_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00 && edge_lvl != 2'b00 && !val_wr) |=>
            ((ch_val == $past(ch_val)) || flag));

    p_capture_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00 && edge_lvl != 2'b00 && !cnt_rst) |=> $stable(pin_out));

    p_flag_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag) |-> $past(flag_wr0));

    p_req_route_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq || dma_req) == (flag && req_en)) && !(irq && dma_req));

    p_req_sel_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !dma_sel);
endmodule

bind tcc_channel tcc_channel_chk #(.CW(CW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (mode),
    .edge_lvl(edge_lvl),
    .cnt_rst (cnt_rst),
    .val_wr  (val_wr),
    .flag_wr0(flag_wr0),
    .flag    (flag),
    .pin_out (pin_out),
    .req_en  (req_en),
    .dma_sel (dma_sel),
    .irq     (irq),
    .dma_req (dma_req),
    .ch_val  (ch_val)
);

// File: tb/tcc_channel_test.sv
module tcc_channel_test;
    localparam int CW   = 16;
    localparam int MODV = 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] cnt = '0;
    logic          cnt_upd = 1'b0, cnt_ovf = 1'b0, cnt_rst = 1'b0;
    logic [1:0]    mode = 2'b00, edge_lvl = 2'b00;
    logic          tov_en = 1'b0, max_duty = 1'b0, req_en = 1'b0, dma_sel = 1'b0;
    logic          val_wr = 1'b0, stat_rd = 1'b0, flag_wr0 = 1'b0, pin_in = 1'b0;
    logic [CW-1:0] val_in = '0;
    logic          pin_out, pin_oe, flag, irq, dma_req;
    logic [CW-1:0] ch_val;

    int n_chk = 0;
    int n_err = 0;
    int bc = 0;
    int wraps = 0;
    logic o_ref;

    always #2 clk = ~clk;

    tcc_channel #(.CW(CW), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .cnt(cnt), .cnt_upd(cnt_upd),
        .cnt_ovf(cnt_ovf), .cnt_rst(cnt_rst), .mode(mode), .edge_lvl(edge_lvl),
        .tov_en(tov_en), .max_duty(max_duty), .req_en(req_en), .dma_sel(dma_sel),
        .val_wr(val_wr), .val_in(val_in), .stat_rd(stat_rd), .flag_wr0(flag_wr0),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .ch_val(ch_val),
        .flag(flag), .irq(irq), .dma_req(dma_req)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_strobes();
        val_wr = 1'b0; stat_rd = 1'b0; flag_wr0 = 1'b0; cnt_rst = 1'b0;
        cnt_upd = 1'b0; cnt_ovf = 1'b0;
    endtask

    // One clock; adv=1 advances the bench counter (wrap after MODV).
    task automatic cyc(input bit adv);
        @(negedge clk);
        clear_strobes();
        if (adv) begin
            if (bc == MODV) begin bc = 0; cnt_ovf = 1'b1; wraps++; end
            else bc++;
            cnt = CW'(bc);
            cnt_upd = 1'b1;
        end
        @(posedge clk); #1;
    endtask

    task automatic adv(input int n);
        for (int i = 0; i < n; i++) cyc(1'b1);
    endtask

    task automatic wr_val(input int v);
        @(negedge clk);
        clear_strobes();
        val_wr = 1'b1; val_in = CW'(v);
        @(posedge clk); #1;
    endtask

    task automatic crst();
        @(negedge clk);
        clear_strobes();
        cnt_rst = 1'b1; bc = 0; cnt = '0;
        @(posedge clk); #1;
    endtask

    task automatic rd();
        @(negedge clk); clear_strobes(); stat_rd = 1'b1;
        @(posedge clk); #1;
    endtask

    task automatic wr0();
        @(negedge clk); clear_strobes(); flag_wr0 = 1'b1;
        @(posedge clk); #1;
    endtask

    task automatic clear_flag();
        rd(); wr0(); cyc(1'b0);
    endtask

    task automatic setcnt(input int v);
        @(negedge clk); clear_strobes(); bc = v; cnt = CW'(v);
        @(posedge clk); #1;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #1;

        // R1 reset state
        chk("R1 reset pin_out", pin_out, 1);
        chk("R1 reset pin_oe", pin_oe, 0);
        chk("R1 reset flag", flag, 0);
        chk("R1 reset ch_val", ch_val, 0);
        chk("R1 reset irq|dma", irq | dma_req, 0);

        // R1 port presets
        mode = 2'b01; edge_lvl = 2'b00; cyc(1'b0);
        chk("R1 preset low", pin_out, 0);
        chk("R1 port oe", pin_oe, 0);
        mode = 2'b10; cyc(1'b0);
        chk("R1 preset high", pin_out, 1);

        // R3 toggle on compare, only on advance
        mode = 2'b01; edge_lvl = 2'b01;
        wr_val(5);
        chk("R3 value write", ch_val, 5);
        crst();
        chk("R3 compare oe", pin_oe, 1);
        chk("R3 before match", pin_out, 1);
        adv(5);
        chk("R3 toggle match", pin_out, 0);
        chk("R3 flag on match", flag, 1);
        repeat (3) cyc(1'b0);
        chk("R3 no action without advance", pin_out, 0);
        adv(10);
        chk("R3 toggle again", pin_out, 1);

        // R8 two-step clear
        wr0(); cyc(1'b0);
        chk("R8 write without read", flag, 1);
        clear_flag();
        chk("R8 read then write", flag, 0);

        // R3 clear and set
        edge_lvl = 2'b10; adv(10);
        chk("R3 clear on match", pin_out, 0);
        edge_lvl = 2'b11; adv(10);
        chk("R3 set on match", pin_out, 1);

        // R6 value beyond wrap
        edge_lvl = 2'b01; wr_val(20); clear_flag();
        adv(30);
        chk("R6 no match pin", pin_out, 1);
        chk("R6 no match flag", flag, 0);

        // R10 counter reset presets
        edge_lvl = 2'b10; crst();
        chk("R10 reset preset low", pin_out, 0);
        edge_lvl = 2'b11; crst();
        chk("R10 reset preset high", pin_out, 1);
        edge_lvl = 2'b10; crst();
        chk("R10 reset preset low again", pin_out, 0);

        // R4 unbuffered PWM sweep, compare 6, wrap after 9
        wr_val(6); tov_en = 1'b1; wraps = 0;
        for (int i = 0; i < 30; i++) begin
            cyc(1'b1);
            chk("R4 pwm level", pin_out, (wraps >= 1 && bc < 6) ? 1 : 0);
        end

        // R7 max duty waits for the next period
        adv(3); max_duty = 1'b1;
        adv(4);
        chk("R7 set waits for wrap", pin_out, 0);
        adv(3);
        chk("R7 forced at wrap", pin_out, 1);
        adv(7);
        chk("R7 forced past compare", pin_out, 1);
        max_duty = 1'b0;
        adv(3);
        chk("R7 release at wrap level", pin_out, 1);
        adv(7);
        chk("R7 normal after release", pin_out, 0);

        // R5 overflow toggle wins over coincident clear
        wr_val(0); crst(); clear_flag();
        adv(5);
        chk("R5 first period", pin_out, 0);
        adv(10);
        chk("R5 toggled period", pin_out, 1);
        adv(10);
        chk("R5 toggled back", pin_out, 0);
        chk("R5 flag still set", flag, 1);
        tov_en = 1'b0;

        // R9 request routing, also in port mode
        edge_lvl = 2'b00; wr_val(5); clear_flag(); crst();
        adv(5);
        chk("R9 flag in port mode", flag, 1);
        chk("R9 port pin level", pin_out, 0);
        chk("R9 port oe", pin_oe, 0);
        req_en = 1'b1; #1;
        chk("R9 irq routed", irq, 1);
        chk("R9 dma idle", dma_req, 0);
        dma_sel = 1'b1; #1;
        chk("R9 dma routed", dma_req, 1);
        chk("R9 irq idle", irq, 0);
        req_en = 1'b0; #1;
        chk("R9 disabled", irq | dma_req, 0);
        dma_sel = 1'b0;

        // R4 wrap toggle ignored in capture
        mode = 2'b00; edge_lvl = 2'b01; tov_en = 1'b1;
        clear_flag(); crst();
        o_ref = pin_out;
        adv(25);
        chk("R4 capture ignores wrap", pin_out, o_ref);
        chk("R4 capture oe", pin_oe, 0);
        chk("R4 capture no flag", flag, 0);
        tov_en = 1'b0;

        // R2 capture polarities
        setcnt(100); pin_in = 1'b1; repeat (4) cyc(1'b0);
        chk("R2 rising value", ch_val, 100);
        chk("R2 rising flag", flag, 1);
        clear_flag();
        edge_lvl = 2'b10; setcnt(200); pin_in = 1'b0; repeat (4) cyc(1'b0);
        chk("R2 falling value", ch_val, 200);
        chk("R2 falling flag", flag, 1);
        clear_flag();
        setcnt(300); pin_in = 1'b1; repeat (4) cyc(1'b0);
        chk("R2 wrong edge value", ch_val, 200);
        chk("R2 wrong edge flag", flag, 0);
        edge_lvl = 2'b11; setcnt(400); pin_in = 1'b0; repeat (4) cyc(1'b0);
        chk("R2 any edge value", ch_val, 400);
        chk("R2 any edge flag", flag, 1);

        finish_run();
    end
endmodule